// File: doc/BRIEF.md
# Fault Protection Auto-Restart Sequencer

This block sits beside the PWM controller of an off-line converter and decides whether switching is allowed. Once per switching cycle it is told, through a cycle-start tick, whether the previous cycle was ended by the overcurrent comparator or by the maximum-duty limit. It also watches three level flags: an over-temperature flag, a flag for excess supply-clamp current, and a flag for an external disable pin above its threshold. Each condition is counted or debounced separately. When one of them is confirmed, the sequencer trips. It then turns the PWM enable off for a fixed restart interval and brings switching back through an eight-step soft-start ramp of the current-limit code.

The block has two kinds of timing. The counts of switching cycles advance on the tick. The debounce windows, the restart interval and the soft-start step length are counted in clock cycles, and each is set by a parameter. The defaults are scaled down for simulation. In the real system they would be about 50 ms of overload, 500 µs of clamp current, 1 ms of disable, 1 s of restart and 8 ms of soft-start. A thermal trip is handled in its own way. After the restart interval, exactly one switching cycle is let through to look at the temperature again. If the flag is still set, a fresh restart interval follows and no soft-start is started.

Top module: `fault_restart_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `pwm_en` is 1, `ilim_code` is 0 and `fault_code` is 0, and the block is in soft-start.
- R2: Soft-start holds each current-limit code from 0 up to 7 for `SS_STEP_CLKS` clocks, with `pwm_en` at 1 all the time. When code 7 has been held for its full step, the block enters normal run with `ilim_code` staying at 7.
- R3: While switching is enabled, a tick with `cyc_ocp` high adds one to an overload count. When the count reaches `OVL_LIMIT`, the block trips with `fault_code` 1.
- R4: A tick with `cyc_ocp` low takes one from the overload count, which does not go below zero. A pattern of two overcurrent ticks followed by two clean ticks therefore never trips.
- R5: `MAXD_LIMIT` consecutive ticks with `cyc_maxd` high trip the block with `fault_code` 2. Any tick with `cyc_maxd` low sets the run back to zero.
- R6: After any trip, `pwm_en` is 0 for exactly `RESTART_CLKS` clocks, whatever the inputs do in that time. When the interval ends, `pwm_en` returns to 1 with `ilim_code` at 0.
- R7: While the block is in normal run, `clamp_oc` held high for `CLAMP_CLKS` consecutive clocks trips the block with `fault_code` 4. A shorter burst does not trip. `clamp_oc` has no effect during soft-start.
- R8: `dis_hi` held high for `DIS_CLKS` consecutive clocks while switching trips the block with `fault_code` 5. A shorter burst does not trip.
- R9: If `temp_hot` is high while the block is switching, the block trips with `fault_code` 3 on the next clock. After the restart interval, one probe cycle follows with `pwm_en` 1 and `ilim_code` 0, and it ends at the next tick. If `temp_hot` is high at that tick, another restart interval starts. If it is low, soft-start starts.
- R10: If several trip conditions are present on the same clock, the cause reported is chosen in this order: thermal, clamp, disable, overload, maximum duty.
- R11: `fault_code` keeps the cause of the most recent trip through the restart interval and the following soft-start. It returns to 0 on entry to normal run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock pulse at the start of each switching cycle |
| cyc_ocp | input | 1 | The cycle just ended was terminated by overcurrent (qualified by `cyc_tick`) |
| cyc_maxd | input | 1 | The cycle just ended was terminated by the maximum-duty limit (qualified by `cyc_tick`) |
| temp_hot | input | 1 | Over-temperature flag |
| clamp_oc | input | 1 | Supply-clamp current above its limit |
| dis_hi | input | 1 | External disable input above threshold |
| pwm_en | output | 1 | Switching allowed |
| ilim_code | output | 3 | Current-limit step, 0 lowest to 7 full scale |
| fault_code | output | 3 | Cause of the last trip: 0 none, 1 overload, 2 max duty, 3 thermal, 4 clamp, 5 disable |

## Verification
The assertions assume that `cyc_tick` is a single-clock pulse and that `cyc_ocp` and `cyc_maxd` are meaningful only on the clock where it is high. They also assume that the three level flags are already synchronised to `clk`, so that a flag held for N clocks is seen on N consecutive edges. The bench drives every input on the falling edge and produces ticks from a fixed divider, one every five clocks. The overcurrent and maximum-duty patterns are indexed by tick number, so each cycle result belongs to exactly one tick.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [1:0] {
    ST_SOFT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_PROBE = 2'd3
  } seq_st_t;

  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_OVERLOAD = 3'd1,
    FC_MAXDUTY  = 3'd2,
    FC_THERMAL  = 3'd3,
    FC_CLAMP    = 3'd4,
    FC_DISABLE  = 3'd5
  } fault_t;

  localparam int ILIM_W = 3;
endpackage

// File: rtl/fr_updown_cnt.sv
// Per-cycle overload accumulator: up on a hit tick, down toward zero otherwise.
module fr_updown_cnt #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  input  logic hit,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) cnt <= '0;
    else if (tick) begin
      if (hit) begin
        if (cnt < CW'(LIMIT)) cnt <= cnt + 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign trip = (cnt == CW'(LIMIT));

  // R3: an armed overcurrent tick raises the count by one
  p_ovl_up_r3: assert property (@(posedge clk) disable iff (rst)
    (arm && tick && hit && cnt < CW'(LIMIT)) |=> (cnt == $past(cnt) + 1'b1));
  // R4: an armed clean tick lowers a nonzero count by one
  p_ovl_down_r4: assert property (@(posedge clk) disable iff (rst)
    (arm && tick && !hit && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fr_streak_cnt.sv
// Consecutive-hit counter: any clean tick restarts the run.
module fr_streak_cnt #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  input  logic hit,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) cnt <= '0;
    else if (tick) begin
      if (!hit) cnt <= '0;
      else if (cnt < CW'(LIMIT)) cnt <= cnt + 1'b1;
    end
  end

  assign trip = (cnt == CW'(LIMIT));

  // R5: a clean tick clears the streak
  p_streak_reset_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !hit) |=> (cnt == '0));
  // R5: the streak never passes its limit
  p_streak_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt <= CW'(LIMIT)));
endmodule

// File: rtl/fr_debounce.sv
// Level debounce counted in clocks; any gap restarts the window.
module fr_debounce #(
  parameter int LIMIT = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic lvl,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || !lvl) cnt <= '0;
    else if (cnt < CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign trip = (cnt == CW'(LIMIT));

  // R7 / R8: a low level empties the window
  p_deb_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!lvl) |=> (cnt == '0));
endmodule

// File: rtl/fault_restart_seq.sv
module fault_restart_seq #(
  parameter int OVL_LIMIT    = 6,
  parameter int MAXD_LIMIT   = 10,
  parameter int CLAMP_CLKS   = 12,
  parameter int DIS_CLKS     = 16,
  parameter int RESTART_CLKS = 40,
  parameter int SS_STEP_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_tick,
  input  logic       cyc_ocp,
  input  logic       cyc_maxd,
  input  logic       temp_hot,
  input  logic       clamp_oc,
  input  logic       dis_hi,
  output logic       pwm_en,
  output logic [2:0] ilim_code,
  output logic [2:0] fault_code
);
  import fr_pkg::*;

  localparam int TW = $clog2(RESTART_CLKS + SS_STEP_CLKS + 1);
  localparam logic [ILIM_W-1:0] ILIM_TOP = {ILIM_W{1'b1}};

  seq_st_t           st;
  logic [TW-1:0]     tmr;
  logic [ILIM_W-1:0] ilim_q;
  logic              pwm_q;
  fault_t            fault_q;

  logic armed, run_arm;
  logic ovl_trip, maxd_trip, clamp_trip, dis_trip;
  fault_t cause;

  assign armed   = (st == ST_SOFT) || (st == ST_RUN);
  assign run_arm = (st == ST_RUN);

  fr_updown_cnt #(.LIMIT(OVL_LIMIT)) u_ovl (
    .clk(clk), .rst(rst), .arm(armed), .tick(cyc_tick), .hit(cyc_ocp), .trip(ovl_trip));

  fr_streak_cnt #(.LIMIT(MAXD_LIMIT)) u_maxd (
    .clk(clk), .rst(rst), .arm(armed), .tick(cyc_tick), .hit(cyc_maxd), .trip(maxd_trip));

  // Clamp check is masked outside normal run (soft-start included)
  fr_debounce #(.LIMIT(CLAMP_CLKS)) u_clamp (
    .clk(clk), .rst(rst), .arm(run_arm), .lvl(clamp_oc), .trip(clamp_trip));

  fr_debounce #(.LIMIT(DIS_CLKS)) u_dis (
    .clk(clk), .rst(rst), .arm(armed), .lvl(dis_hi), .trip(dis_trip));

  // Trip cause, highest precedence first
  always_comb begin
    cause = FC_NONE;
    if (armed) begin
      if (temp_hot)        cause = FC_THERMAL;
      else if (clamp_trip) cause = FC_CLAMP;
      else if (dis_trip)   cause = FC_DISABLE;
      else if (ovl_trip)   cause = FC_OVERLOAD;
      else if (maxd_trip)  cause = FC_MAXDUTY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_SOFT;
      tmr     <= '0;
      ilim_q  <= '0;
      pwm_q   <= 1'b1;
      fault_q <= FC_NONE;
    end else begin
      case (st)
        ST_SOFT, ST_RUN: begin
          if (cause != FC_NONE) begin
            st      <= ST_HOLD;
            tmr     <= '0;
            ilim_q  <= '0;
            pwm_q   <= 1'b0;
            fault_q <= cause;
          end else if (st == ST_SOFT) begin
            if (tmr == TW'(SS_STEP_CLKS - 1)) begin
              tmr <= '0;
              if (ilim_q == ILIM_TOP) begin
                st      <= ST_RUN;
                fault_q <= FC_NONE;
              end else begin
                ilim_q <= ilim_q + 1'b1;
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tmr == TW'(RESTART_CLKS - 1)) begin
            tmr    <= '0;
            pwm_q  <= 1'b1;
            ilim_q <= '0;
            st     <= (fault_q == FC_THERMAL) ? ST_PROBE : ST_SOFT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin // ST_PROBE: one cycle to look at the temperature again
          if (cyc_tick) begin
            tmr <= '0;
            if (temp_hot) begin
              st    <= ST_HOLD;
              pwm_q <= 1'b0;
            end else begin
              st <= ST_SOFT;
            end
          end
        end
      endcase
    end
  end

  assign pwm_en     = pwm_q;
  assign ilim_code  = ilim_q;
  assign fault_code = fault_q;

  // R2: during soft-start the code only holds or climbs by one, unless a trip zeroes the enable
  p_soft_ramp_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SOFT) |=> (!pwm_q || ilim_q == $past(ilim_q) || ilim_q == $past(ilim_q) + 1'b1));
  // R6: switching is off for the whole restart interval
  p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> !pwm_q);
  // R7: the clamp window never fills during soft-start
  p_clamp_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SOFT) |-> !clamp_trip);
  // R9: a hot flag while switching removes the enable on the next clock
  p_hot_trip_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && temp_hot) |=> !pwm_q);
  // R11: normal run always has a clear status and full-scale limit
  p_run_clean_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (fault_q == FC_NONE && ilim_q == ILIM_TOP));
endmodule

// File: tb/sim_fault_restart_seq.sv
`timescale 1ns/1ps
module sim_fault_restart_seq;
  localparam int OVL = 6, MXD = 10, CLP = 12, DSB = 16, RST_C = 40, SSS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_tick = 1'b0, cyc_ocp = 1'b0, cyc_maxd = 1'b0;
  logic temp_hot = 1'b0, clamp_oc = 1'b0, dis_hi = 1'b0;
  logic pwm_en;
  logic [2:0] ilim_code, fault_code;

  int n_run = 0, n_fail = 0;
  int ocp_mode = 0, maxd_mode = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  fault_restart_seq #(.OVL_LIMIT(OVL), .MAXD_LIMIT(MXD), .CLAMP_CLKS(CLP),
    .DIS_CLKS(DSB), .RESTART_CLKS(RST_C), .SS_STEP_CLKS(SSS)) u0 (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .cyc_ocp(cyc_ocp), .cyc_maxd(cyc_maxd),
    .temp_hot(temp_hot), .clamp_oc(clamp_oc), .dis_hi(dis_hi),
    .pwm_en(pwm_en), .ilim_code(ilim_code), .fault_code(fault_code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle tick generator: one tick every five clocks, cycle results indexed by tick number
  initial begin
    int div = 0;
    int k = 0;
    forever begin
      @(negedge clk);
      div = (div == 4) ? 0 : div + 1;
      cyc_tick = (div == 4);
      if (cyc_tick) k++;
      cyc_ocp  = (ocp_mode == 1) || (ocp_mode == 2 && ((k / 2) % 2 == 1));
      cyc_maxd = (maxd_mode == 1) || (maxd_mode == 3 && (k % 10 != 9));
    end
  end

  // Behavioural reference model
  int m_st, m_tmr, m_ilim, m_pwm, m_flt;
  int c_ovl, c_mx, c_cl, c_ds;
  always @(posedge clk) begin
    int t;
    bit arm;
    bit runm;
    if (rst) begin
      m_st = 0; m_tmr = 0; m_ilim = 0; m_pwm = 1; m_flt = 0;
      c_ovl = 0; c_mx = 0; c_cl = 0; c_ds = 0;
      model_on = 1'b1;
    end else begin
      arm  = (m_st == 0 || m_st == 1);
      runm = (m_st == 1);
      t = 0;
      if (arm) begin
        if (temp_hot) t = 3;
        else if (c_cl >= CLP) t = 4;
        else if (c_ds >= DSB) t = 5;
        else if (c_ovl >= OVL) t = 1;
        else if (c_mx >= MXD) t = 2;
      end
      if (!arm) begin c_ovl = 0; c_mx = 0; end
      else if (cyc_tick) begin
        if (cyc_ocp) c_ovl = (c_ovl < OVL) ? c_ovl + 1 : c_ovl;
        else if (c_ovl > 0) c_ovl = c_ovl - 1;
        c_mx = cyc_maxd ? ((c_mx < MXD) ? c_mx + 1 : c_mx) : 0;
      end
      c_cl = (runm && clamp_oc) ? ((c_cl < CLP) ? c_cl + 1 : c_cl) : 0;
      c_ds = (arm && dis_hi) ? ((c_ds < DSB) ? c_ds + 1 : c_ds) : 0;
      if (arm && t != 0) begin
        m_st = 2; m_tmr = 0; m_ilim = 0; m_pwm = 0; m_flt = t;
      end else if (m_st == 0) begin
        m_tmr++;
        if (m_tmr == SSS) begin
          m_tmr = 0;
          if (m_ilim == 7) begin m_st = 1; m_flt = 0; end
          else m_ilim++;
        end
      end else if (m_st == 2) begin
        m_tmr++;
        if (m_tmr == RST_C) begin
          m_tmr = 0; m_pwm = 1; m_ilim = 0;
          m_st = (m_flt == 3) ? 3 : 0;
        end
      end else if (m_st == 3 && cyc_tick) begin
        m_tmr = 0;
        if (temp_hot) begin m_st = 2; m_pwm = 0; end
        else m_st = 0;
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      chk(pwm_en == m_pwm[0], "R6 model pwm_en", pwm_en, m_pwm);
      chk(ilim_code == m_ilim[2:0], "R2 model ilim_code", ilim_code, m_ilim);
      chk(fault_code == m_flt[2:0], "R11 model fault_code", fault_code, m_flt);
    end
  end

  task automatic wait_pwm(input bit lvl, input int maxc, output int n);
    n = 0;
    while (pwm_en != lvl && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(pwm_en == 1'b1, "R1 pwm_en in reset", pwm_en, 1);
    chk(ilim_code == 3'd0, "R1 ilim_code in reset", ilim_code, 0);
    chk(fault_code == 3'd0, "R1 fault_code in reset", fault_code, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ilim_code == 3'd0 && pwm_en, "R1 first cycle after reset", ilim_code, 0);
    repeat (33) @(negedge clk);
    chk(ilim_code == 3'd7, "R2 full scale after ramp", ilim_code, 7);

    // R4: balanced overcurrent pattern never trips
    ocp_mode = 2;
    repeat (200) @(negedge clk);
    chk(pwm_en == 1'b1, "R4 intermittent overcurrent no trip", pwm_en, 1);
    ocp_mode = 0;

    // R3 then R6 restart interval
    ocp_mode = 1;
    wait_pwm(1'b0, 200, n);
    chk(fault_code == 3'd1, "R3 overload code", fault_code, 1);
    ocp_mode = 0;
    n = 0;
    while (pwm_en == 1'b0 && n < 200) begin @(negedge clk); n++; end
    chk(n == RST_C, "R6 restart length", n, RST_C);
    chk(ilim_code == 3'd0, "R6 ramp restarts at zero", ilim_code, 0);
    chk(fault_code == 3'd1, "R11 code held through soft-start", fault_code, 1);

    // R7: clamp masked during soft-start
    clamp_oc = 1'b1;
    repeat (28) @(negedge clk);
    clamp_oc = 1'b0;
    repeat (10) @(negedge clk);
    chk(pwm_en == 1'b1, "R7 clamp ignored in soft-start", pwm_en, 1);
    chk(fault_code == 3'd0, "R11 code cleared in run", fault_code, 0);
    clamp_oc = 1'b1;
    repeat (11) @(negedge clk);
    clamp_oc = 1'b0;
    repeat (3) @(negedge clk);
    chk(pwm_en == 1'b1, "R7 short clamp burst", pwm_en, 1);
    clamp_oc = 1'b1;
    wait_pwm(1'b0, 40, n);
    chk(fault_code == 3'd4, "R7 clamp code", fault_code, 4);
    clamp_oc = 1'b0;
    wait_pwm(1'b1, 100, n);
    repeat (40) @(negedge clk);

    // R8: disable debounce
    dis_hi = 1'b1;
    repeat (15) @(negedge clk);
    dis_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk(pwm_en == 1'b1, "R8 short disable burst", pwm_en, 1);
    dis_hi = 1'b1;
    wait_pwm(1'b0, 60, n);
    chk(fault_code == 3'd5, "R8 disable code", fault_code, 5);
    dis_hi = 1'b0;
    wait_pwm(1'b1, 100, n);
    repeat (40) @(negedge clk);

    // R5: maximum-duty streak
    maxd_mode = 3;
    repeat (300) @(negedge clk);
    chk(pwm_en == 1'b1, "R5 nine in a row no trip", pwm_en, 1);
    maxd_mode = 1;
    wait_pwm(1'b0, 200, n);
    chk(fault_code == 3'd2, "R5 max duty code", fault_code, 2);
    maxd_mode = 0;
    wait_pwm(1'b1, 100, n);
    repeat (40) @(negedge clk);

    // R10: thermal wins over a simultaneous disable trip
    dis_hi = 1'b1;
    repeat (DSB) @(negedge clk);
    temp_hot = 1'b1;
    @(negedge clk);
    chk(fault_code == 3'd3, "R10 thermal takes precedence", fault_code, 3);
    dis_hi = 1'b0;
    temp_hot = 1'b0;
    wait_pwm(1'b1, 100, n);
    @(negedge clk);
    wait_pwm(1'b1, 20, n);
    repeat (40) @(negedge clk);

    // R9: thermal trip, probe, re-hold, then recovery
    temp_hot = 1'b1;
    @(negedge clk);
    chk(pwm_en == 1'b0, "R9 immediate thermal trip", pwm_en, 0);
    chk(fault_code == 3'd3, "R9 thermal code", fault_code, 3);
    wait_pwm(1'b1, 60, n);
    chk(ilim_code == 3'd0 && fault_code == 3'd3, "R9 probe cycle", ilim_code, 0);
    wait_pwm(1'b0, 20, n);
    chk(pwm_en == 1'b0, "R9 still hot holds again", pwm_en, 0);
    temp_hot = 1'b0;
    wait_pwm(1'b1, 60, n);
    repeat (20) @(negedge clk);
    chk(pwm_en == 1'b1, "R9 cool probe resumes", pwm_en, 1);
    repeat (40) @(negedge clk);
    chk(fault_code == 3'd0 && ilim_code == 3'd7, "R11 clear after thermal recovery", fault_code, 0);

    finish_run();
  end
endmodule